// File: doc/BRIEF.md
# Timer Channel Trigger and Clock Gate

This block is the control core of one timer/counter channel. It keeps a counter whose width is a parameter (16 bits by default), gates its count-enable through two latches, and merges four trigger sources into one restart command. Each trigger clears the counter and starts it. The counter advances on a per-cycle clock tick that is selected outside the block. The channel runs in capture mode, where pins A and B are inputs, or in waveform mode, where pin A drives and pin B drives unless pin B is the chosen external trigger.

The two latches are held as one three-state machine. In OFF the enable latch is clear. In HALT the enable latch is set and the run latch is clear. In RUN both latches are set. The transitions are: OFF to HALT on an enable request without a disable request. HALT to RUN on an effective trigger. RUN to RUN on a trigger, which restarts the count. RUN to HALT on a stop event with no trigger. HALT or RUN to OFF on any disable request. The stop event depends on the mode. In capture mode it is a register-B load event when stop-on-load is set. In waveform mode it is an RC compare hit when stop-on-RC is set.

The trigger sources are a software strobe, a sync strobe that all channels share, an RC compare hit when its enable is set, and a rising edge on a mode-dependent external line when the external enable is set.

Top module: `tmr_chan_trig`

## Requirements
- R1: After reset the counter is 0, clk_on and running are low, and rc_hit and ovf are low.
- R2: clk_en_req sets the enable latch (clk_on high from the next cycle). clk_dis_req clears it and stops the run latch. When both requests arrive in the same cycle, the disable wins.
- R3: While clk_on is low, triggers are ignored and the counter keeps its value, even with tick high. A trigger in the same cycle as an enable request from OFF is also ignored.
- R4: While clk_on is high, a sw_trig or sync_in strobe sets the counter to 0 and sets running in the next cycle.
- R5: In RUN, the counter goes up by one on each cycle with tick high. It holds when tick is low or running is low.
- R6: rc_hit is high in the cycle in which the counter has just stepped to rc_val. With rc_trig_en set, the counter is 0 in the following cycle. With rc_trig_en clear, it keeps counting.
- R7: With ext_trig_en set, a rising edge of the selected line triggers in the same way as sw_trig. In capture mode ext_sel[0]=0 picks pin A and ext_sel[0]=1 picks pin B. In waveform mode ext_sel=0 picks pin B and ext_sel=1,2,3 pick xc_in[0],[1],[2]. Edges on other lines, or any edge with ext_trig_en clear, have no effect.
- R8: An automatic stop clears running and freezes the counter at its value. In capture mode the stop comes from ldb_evt with stop_on_ldb set. In waveform mode it comes from rc_hit with stop_on_rc set.
- R9: When a trigger and a stop event occur in the same cycle, the trigger wins: the counter becomes 0 and running stays high.
- R10: A step from the all-ones value wraps the counter to 0, and ovf is high for exactly that one following cycle.
- R11: pin_a_oe equals mode_wave. pin_b_oe is high only in waveform mode with ext_sel not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wave | input | 1 | 1 = waveform mode, 0 = capture mode |
| clk_en_req | input | 1 | Enable-latch set strobe |
| clk_dis_req | input | 1 | Enable-latch clear strobe (dominant) |
| sw_trig | input | 1 | Software trigger strobe |
| sync_in | input | 1 | Shared multi-channel sync strobe |
| tick | input | 1 | Selected counter clock tick |
| rc_val | input | CNT_W | RC compare value |
| rc_trig_en | input | 1 | RC compare trigger enable |
| ext_sel | input | 2 | External trigger line select |
| ext_trig_en | input | 1 | External trigger enable |
| pin_a_in | input | 1 | Pin A input level |
| pin_b_in | input | 1 | Pin B input level |
| xc_in | input | 3 | External clock lines 0..2 |
| stop_on_ldb | input | 1 | Stop on register-B load (capture) |
| ldb_evt | input | 1 | Register-B load event |
| stop_on_rc | input | 1 | Stop on RC compare (waveform) |
| count | output | CNT_W | Counter value |
| rc_hit | output | 1 | RC compare event |
| ovf | output | 1 | Counter wrap pulse |
| clk_on | output | 1 | Enable latch state |
| running | output | 1 | Run latch state |
| pin_a_oe | output | 1 | Pin A drive enable |
| pin_b_oe | output | 1 | Pin B drive enable |

## Verification
The external trigger path is swept over both modes, all four select codes and all five candidate lines. Each case shows whether the counter restarts or steps to 4, so a wrong line, a wrong mode decode or a missing enable gate shows up as a count value. The counting path is driven with an irregular tick pattern, which separates per-tick stepping from per-cycle stepping. The RC path is run with the restart enabled and disabled, which separates repeat mode from pass-through. Stop events are driven alone and together with triggers, to test the priority rule. A full 16-bit run checks the wrap and the single-cycle overflow pulse.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

    typedef enum logic [1:0] {
        CS_OFF  = 2'd0,
        CS_HALT = 2'd1,
        CS_RUN  = 2'd2
    } chan_st_t;

endpackage

// File: rtl/tcc_trig_merge.sv
module tcc_trig_merge #(
    parameter int XC_N  = 3,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wave,
    input  logic [SEL_W-1:0] ext_sel,
    input  logic             ext_trig_en,
    input  logic             pin_a_in,
    input  logic             pin_b_in,
    input  logic [XC_N-1:0]  xc_in,
    input  logic             sw_trig,
    input  logic             sync_in,
    input  logic             rc_hit,
    input  logic             rc_trig_en,
    output logic             trig_any
);
    localparam int LINES = 2 ** SEL_W;

    logic [LINES-1:0] wave_lines;
    logic             cap_src;
    logic             ext_src;
    logic             ext_src_q;
    logic             ext_evt;

    // waveform candidates: slot 0 = pin B, slot k = external line k-1
    for (genvar g = 0; g < LINES; g++) begin : g_line
        if (g == 0) begin : g_b
            assign wave_lines[g] = pin_b_in;
        end else if (g <= XC_N) begin : g_xc
            assign wave_lines[g] = xc_in[g-1];
        end else begin : g_none
            assign wave_lines[g] = 1'b0;
        end
    end

    assign cap_src = ext_sel[0] ? pin_b_in : pin_a_in;
    assign ext_src = mode_wave ? wave_lines[ext_sel] : cap_src;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_src_q <= 1'b0;
        end else begin
            ext_src_q <= ext_src;
        end
    end

    assign ext_evt  = ext_trig_en && ext_src && !ext_src_q;
    assign trig_any = sw_trig || sync_in || (rc_hit && rc_trig_en) || ext_evt;

endmodule

// File: rtl/tcc_run_fsm.sv
module tcc_run_fsm
    import tmr_chan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clk_en_req,
    input  logic clk_dis_req,
    input  logic trig_any,
    input  logic stop_evt,
    output logic trig_eff,
    output logic clk_on,
    output logic running
);
    chan_st_t state;
    chan_st_t state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CS_OFF;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            CS_OFF: begin
                if (clk_en_req && !clk_dis_req) state_nx = CS_HALT;
            end
            CS_HALT: begin
                if (clk_dis_req)   state_nx = CS_OFF;
                else if (trig_any) state_nx = CS_RUN;
            end
            CS_RUN: begin
                if (clk_dis_req)   state_nx = CS_OFF;
                else if (trig_any) state_nx = CS_RUN;
                else if (stop_evt) state_nx = CS_HALT;
            end
            default: state_nx = CS_OFF;
        endcase
    end

    always_comb begin
        clk_on   = (state != CS_OFF);
        running  = (state == CS_RUN);
        trig_eff = trig_any && (state != CS_OFF) && !clk_dis_req;
    end

endmodule

// File: rtl/tcc_counter.sv
module tcc_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_eff,
    input  logic             run_en,
    input  logic             tick,
    input  logic             stop_evt,
    input  logic [CNT_W-1:0] rc_val,
    output logic [CNT_W-1:0] count,
    output logic             rc_hit,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             inc;
    logic [CNT_W-1:0] count_inc;

    assign inc       = run_en && tick && !stop_evt && !trig_eff;
    assign count_inc = count + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count  <= '0;
            rc_hit <= 1'b0;
            ovf    <= 1'b0;
        end else if (trig_eff) begin
            count  <= '0;
            rc_hit <= 1'b0;
            ovf    <= 1'b0;
        end else begin
            if (inc) count <= count_inc;
            rc_hit <= inc && (count_inc == rc_val);
            ovf    <= inc && (count == CNT_MAX);
        end
    end

endmodule

// File: rtl/tmr_chan_trig.sv
module tmr_chan_trig #(
    parameter int CNT_W = 16,
    parameter int XC_N  = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       mode_wave,
    input  logic                       clk_en_req,
    input  logic                       clk_dis_req,
    input  logic                       sw_trig,
    input  logic                       sync_in,
    input  logic                       tick,
    input  logic [CNT_W-1:0]           rc_val,
    input  logic                       rc_trig_en,
    input  logic [$clog2(XC_N+1)-1:0]  ext_sel,
    input  logic                       ext_trig_en,
    input  logic                       pin_a_in,
    input  logic                       pin_b_in,
    input  logic [XC_N-1:0]            xc_in,
    input  logic                       stop_on_ldb,
    input  logic                       ldb_evt,
    input  logic                       stop_on_rc,
    output logic [CNT_W-1:0]           count,
    output logic                       rc_hit,
    output logic                       ovf,
    output logic                       clk_on,
    output logic                       running,
    output logic                       pin_a_oe,
    output logic                       pin_b_oe
);
    localparam int SEL_W = $clog2(XC_N + 1);

    logic trig_any;
    logic trig_eff;
    logic stop_evt;

    tcc_trig_merge #(.XC_N(XC_N), .SEL_W(SEL_W)) u_merge (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_wave   (mode_wave),
        .ext_sel     (ext_sel),
        .ext_trig_en (ext_trig_en),
        .pin_a_in    (pin_a_in),
        .pin_b_in    (pin_b_in),
        .xc_in       (xc_in),
        .sw_trig     (sw_trig),
        .sync_in     (sync_in),
        .rc_hit      (rc_hit),
        .rc_trig_en  (rc_trig_en),
        .trig_any    (trig_any)
    );

    tcc_run_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .clk_en_req  (clk_en_req),
        .clk_dis_req (clk_dis_req),
        .trig_any    (trig_any),
        .stop_evt    (stop_evt),
        .trig_eff    (trig_eff),
        .clk_on      (clk_on),
        .running     (running)
    );

    tcc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_eff (trig_eff),
        .run_en   (running),
        .tick     (tick),
        .stop_evt (stop_evt),
        .rc_val   (rc_val),
        .count    (count),
        .rc_hit   (rc_hit),
        .ovf      (ovf)
    );

    // automatic stop: load event in capture mode, compare hit in waveform mode
    assign stop_evt = running && (mode_wave ? (stop_on_rc && rc_hit)
                                            : (stop_on_ldb && ldb_evt));

    assign pin_a_oe = mode_wave;
    assign pin_b_oe = mode_wave && (ext_sel != '0);

endmodule

// File: rtl/tmr_chan_trig_chk.sv
module tmr_chan_trig_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clk_en_req,
    input logic             clk_dis_req,
    input logic             tick,
    input logic [CNT_W-1:0] count,
    input logic             ovf,
    input logic             clk_on,
    input logic             running,
    input logic             trig_eff,
    input logic             stop_evt
);
    p_dis_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clk_dis_req |=> (!clk_on && !running));

    p_en_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en_req && !clk_dis_req) |=> clk_on);

    p_off_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_on |=> $stable(count));

    p_trig_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trig_eff |=> (running && count == '0));

    p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && !trig_eff && !stop_evt && !clk_dis_req)
        |=> count == CNT_W'($past(count) + 1));

    p_stop_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_evt && !trig_eff && !clk_dis_req) |=> (!running && $stable(count)));

    p_trig_beats_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_evt && trig_eff) |=> running);

    p_ovf_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (count == '0));

    p_ovf_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> !ovf);

endmodule

bind tmr_chan_trig tmr_chan_trig_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clk_en_req  (clk_en_req),
    .clk_dis_req (clk_dis_req),
    .tick        (tick),
    .count       (count),
    .ovf         (ovf),
    .clk_on      (clk_on),
    .running     (running),
    .trig_eff    (trig_eff),
    .stop_evt    (stop_evt)
);

// File: tb/tmr_chan_trig_bench.sv
`timescale 1ns/1ps
module tmr_chan_trig_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_wave = 1'b0;
    logic        clk_en_req = 1'b0;
    logic        clk_dis_req = 1'b0;
    logic        sw_trig = 1'b0;
    logic        sync_in = 1'b0;
    logic        tick = 1'b0;
    logic [15:0] rc_val = 16'd0;
    logic        rc_trig_en = 1'b0;
    logic [1:0]  ext_sel = 2'd0;
    logic        ext_trig_en = 1'b0;
    logic        pin_a_in = 1'b0;
    logic        pin_b_in = 1'b0;
    logic [2:0]  xc_in = 3'd0;
    logic        stop_on_ldb = 1'b0;
    logic        ldb_evt = 1'b0;
    logic        stop_on_rc = 1'b0;
    logic [15:0] count;
    logic        rc_hit;
    logic        ovf;
    logic        clk_on;
    logic        running;
    logic        pin_a_oe;
    logic        pin_b_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    tmr_chan_trig u_tmr_chan_trig (
        .clk(clk), .rst_n(rst_n), .mode_wave(mode_wave),
        .clk_en_req(clk_en_req), .clk_dis_req(clk_dis_req),
        .sw_trig(sw_trig), .sync_in(sync_in), .tick(tick),
        .rc_val(rc_val), .rc_trig_en(rc_trig_en), .ext_sel(ext_sel),
        .ext_trig_en(ext_trig_en), .pin_a_in(pin_a_in), .pin_b_in(pin_b_in),
        .xc_in(xc_in), .stop_on_ldb(stop_on_ldb), .ldb_evt(ldb_evt),
        .stop_on_rc(stop_on_rc), .count(count), .rc_hit(rc_hit), .ovf(ovf),
        .clk_on(clk_on), .running(running), .pin_a_oe(pin_a_oe),
        .pin_b_oe(pin_b_oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic trig_pulse();
        sw_trig = 1'b1;
        step();
        sw_trig = 1'b0;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int exp_cnt;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 count", count, 0);
        chk("R1 clk_on", clk_on, 0);
        chk("R1 running", running, 0);
        chk("R1 rc_hit/ovf", {rc_hit, ovf}, 0);

        // R3 trigger ignored while disabled, tick high
        tick = 1'b1;
        trig_pulse();
        chk("R3 running after trig in OFF", running, 0);
        step();
        chk("R3 count held in OFF", count, 0);
        tick = 1'b0;

        // R2 enable and disable together: disable wins
        clk_en_req = 1'b1; clk_dis_req = 1'b1;
        step();
        clk_en_req = 1'b0; clk_dis_req = 1'b0;
        chk("R2 dis wins clk_on", clk_on, 0);

        // R3 trigger together with enable from OFF is ignored
        clk_en_req = 1'b1; sw_trig = 1'b1;
        step();
        clk_en_req = 1'b0; sw_trig = 1'b0;
        chk("R2 clk_on after enable", clk_on, 1);
        chk("R3 running after enable+trig", running, 0);

        // R4 software trigger starts
        trig_pulse();
        chk("R4 running after sw_trig", running, 1);
        chk("R4 count after sw_trig", count, 0);

        // R5 irregular tick pattern
        exp_cnt = 0;
        for (int i = 0; i < 40; i++) begin
            tick = (i % 3 != 0) || (i % 7 == 0);
            step();
            if (tick) exp_cnt++;
            chk("R5 count step", count, exp_cnt);
        end
        tick = 1'b0;

        // R4 sync acts as trigger
        sync_in = 1'b1;
        step();
        sync_in = 1'b0;
        chk("R4 count after sync", count, 0);
        chk("R4 running after sync", running, 1);
        tick = 1'b1;
        repeat (5) step();
        tick = 1'b0;
        chk("R5 count after 5 ticks", count, 5);

        // R2 disable stops, R3 count held
        clk_dis_req = 1'b1;
        step();
        clk_dis_req = 1'b0;
        chk("R2 clk_on after disable", clk_on, 0);
        chk("R2 running after disable", running, 0);
        tick = 1'b1;
        sync_in = 1'b1;
        step();
        sync_in = 1'b0;
        repeat (3) step();
        tick = 1'b0;
        chk("R3 count held while off", count, 5);
        clk_en_req = 1'b1;
        step();
        clk_en_req = 1'b0;
        chk("R2 re-enable halted", {clk_on, running}, 2);
        chk("R5 count held while halted", count, 5);

        // R6 RC restart
        rc_val = 16'd5; rc_trig_en = 1'b1;
        trig_pulse();
        tick = 1'b1;
        exp_cnt = 0;
        for (int i = 0; i < 14; i++) begin
            step();
            exp_cnt = (exp_cnt == 5) ? 0 : exp_cnt + 1;
            chk("R6 rc restart count", count, exp_cnt);
            chk("R6 rc_hit", rc_hit, (exp_cnt == 5) ? 1 : 0);
        end
        rc_trig_en = 1'b0;
        while (count != 16'd4) step();
        repeat (3) step();
        chk("R6 no restart when disabled", count, 7);
        tick = 1'b0;

        // R8 waveform stop on RC
        mode_wave = 1'b1; stop_on_rc = 1'b1; rc_val = 16'd4;
        trig_pulse();
        tick = 1'b1;
        repeat (6) step();
        chk("R8 wave stop count", count, 4);
        chk("R8 wave stop running", running, 0);

        // R9 trigger beats stop (rc trigger with stop on rc)
        rc_trig_en = 1'b1;
        trig_pulse();
        repeat (5) step();
        chk("R9 wave trig beats stop count", count, 0);
        chk("R9 wave trig beats stop running", running, 1);
        tick = 1'b0;
        rc_trig_en = 1'b0; stop_on_rc = 1'b0;

        // R8 capture stop on load event
        mode_wave = 1'b0; stop_on_ldb = 1'b1; rc_val = 16'd0;
        trig_pulse();
        tick = 1'b1;
        repeat (3) step();
        ldb_evt = 1'b1;
        step();
        ldb_evt = 1'b0;
        chk("R8 capture stop running", running, 0);
        step();
        chk("R8 capture stop count", count, 3);
        // R9 trigger and load event together
        sw_trig = 1'b1; ldb_evt = 1'b1;
        step();
        sw_trig = 1'b0; ldb_evt = 1'b0;
        chk("R9 capture trig beats stop", {running, count}, 32'h1_0000);
        tick = 1'b0;
        stop_on_ldb = 1'b0;

        // R7 external source sweep: lines 0=A 1=B 2..4=XC0..2
        ext_trig_en = 1'b1;
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                for (int ln = 0; ln < 5; ln++) begin
                    bit hit;
                    mode_wave = m[0];
                    ext_sel = s[1:0];
                    if (m == 0) hit = s[0] ? (ln == 1) : (ln == 0);
                    else        hit = (s == 0) ? (ln == 1) : (ln == s + 1);
                    trig_pulse();
                    tick = 1'b1;
                    repeat (3) step();
                    case (ln)
                        0: pin_a_in = 1'b1;
                        1: pin_b_in = 1'b1;
                        default: xc_in[ln-2] = 1'b1;
                    endcase
                    step();
                    pin_a_in = 1'b0; pin_b_in = 1'b0; xc_in = 3'd0;
                    tick = 1'b0;
                    chk($sformatf("R7 ext m%0d s%0d l%0d", m, s, ln),
                        count, hit ? 0 : 4);
                    step();
                end
            end
        end
        // R7 matching edge with enable clear has no effect
        ext_trig_en = 1'b0; mode_wave = 1'b1; ext_sel = 2'd2;
        trig_pulse();
        tick = 1'b1;
        repeat (3) step();
        xc_in[1] = 1'b1;
        step();
        xc_in = 3'd0;
        tick = 1'b0;
        chk("R7 ext disabled", count, 4);

        // R11 pin directions
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                mode_wave = m[0];
                ext_sel = s[1:0];
                #0.5;
                chk("R11 pin_a_oe", pin_a_oe, m);
                chk("R11 pin_b_oe", pin_b_oe, (m == 1 && s != 0) ? 1 : 0);
            end
        end
        step();

        // R10 wrap and overflow pulse
        mode_wave = 1'b0; ext_sel = 2'd0; rc_val = 16'd0;
        trig_pulse();
        tick = 1'b1;
        repeat (65535) step();
        chk("R10 count at max", count, 65535);
        chk("R10 no ovf before wrap", ovf, 0);
        step();
        chk("R10 wrap count", count, 0);
        chk("R10 ovf pulse", ovf, 1);
        step();
        chk("R10 ovf single", ovf, 0);
        chk("R10 count after wrap", count, 1);
        tick = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule